// File: doc/BRIEF.md
# Debounced Comparator Threshold Detector

This block qualifies the single-bit output of an analog comparator that reports whether a coil voltage is above a reference level. The raw bit first passes through a two-flop synchronizer. It is then sampled once per tick of a selectable sample rate: the machine clock divided by 1, 2, 4 or 8. A result flag is raised once the required number of consecutive samples have all been high. The flag stays set until software clears it, or until the detector is disabled.

Software drives the block through one 16-bit control/status word that has a write strobe, two byte-lane enables and a read-data bus. A power-down field drives an output that switches off the analog comparator and its reference source. The enable, power-down and result fields are also brought out as pins.

The qualifier is a three-state machine:
- ST_OFF: disabled, with the run counter cleared.
- ST_COUNT: counting consecutive high samples.
- ST_HIT: result set.

Its transitions are:
- *enable-drop*: any state to ST_OFF when the enable field is 0.
- *arm*: ST_OFF to ST_COUNT when enabled.
- *qualify*: ST_COUNT to ST_HIT on a high sample that completes the run.
- *soft-clear*: ST_COUNT or ST_HIT to ST_COUNT, with the run counter zeroed, when software writes 0 to the result bit.

While in ST_COUNT, a low sample on a tick zeroes the run counter.

Top module: `thresh_qual`

## Requirements
- R1: Field `rate` (bits 15:14) selects one sample tick every 1, 2, 4 or 8 clock cycles for codes 00, 01, 10 and 11. The ticks are derived from a free-running prescaler that is 0 out of reset, and a tick occurs when the prescaler value modulo the divisor is 0.
- R2: The comparator bit reaches the sampler through two register stages. With rate 00 and a one-sample requirement, a rising input shows on `result_o` after the third rising clock edge and not before.
- R3: Field `nsamp` (bits 12:10) with code n requires n+1 consecutive high samples. Codes 5, 6 and 7 all require 5.
- R4: A low sample taken on a tick resets the consecutive-high count to zero.
- R5: The result sets on the tick that completes the required run. It then stays set regardless of the comparator input.
- R6: A write with the upper byte lane enabled and bit 8 = 0 clears the result and restarts the count. Writing bit 8 = 1 never sets the result.
- R7: While field `en` (bit 13) is 0, the result reads 0 on bit 8 and on `result_o`, and the run count is cleared. Re-enabling starts a fresh count.
- R8: Field `pd` (bit 9) drives `pwrdn_o` directly, and `en` drives `det_en_o`.
- R9: Bits 7:0 read 0. A write with byte lane 1 (`reg_be[1]`) low leaves every field unchanged.
- R10: After reset, all fields and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control/status word |
| reg_be | input | 2 | Byte-lane enables; bit 1 covers bits 15:8 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data: control fields and result |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = above reference |
| det_en_o | output | 1 | Detector enable |
| pwrdn_o | output | 1 | Power-down for comparator and reference source |
| result_o | output | 1 | Sticky qualified result, gated by enable |

## Verification
The bench targets four things: the exact synchronizer latency, the phase of the sample tick at each divisor, the saturation of sample-count codes 5 to 7, and input runs that break one sample short of qualifying. A wrong design in these areas would flag a result one cycle early, sample on the wrong edges, or demand 6 to 8 samples. It also exercises a soft-clear write that lands while a qualifying run is in progress, and a write with bit 8 = 1 that must not set the result. Disabling and re-enabling mid-run is covered, where a stale run count would qualify the input too soon. Random writes, including writes on the lower lane only, test that such writes are ignored, while a biased random comparator input produces frequent near-miss runs.

// File: rtl/thq_pkg.sv
package thq_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HIT   = 2'd2
    } thq_state_e;

    typedef struct packed {
        logic [1:0] rate;
        logic       en;
        logic [2:0] nsamp;
        logic       pd;
    } thq_ctrl_t;
endpackage

// File: rtl/thq_sync.sv
module thq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b0;
                end else begin
                    chain_q[gi] <= (gi == 0) ? d : chain_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/thq_prescale.sv
module thq_prescale #(
    parameter int PS_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (rate)
            2'd0:    mask = PS_W'(0);
            2'd1:    mask = PS_W'(1);
            2'd2:    mask = PS_W'(3);
            default: mask = PS_W'(7);
        endcase
    end

    assign tick = ((pcnt_q & mask) == '0);

    // R1: with a divisor above 1, two ticks never fall on adjacent cycles
    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (rate != 2'd0 && $stable(rate)) |-> !(tick && $past(tick)));
endmodule

// File: rtl/thq_ctrl_reg.sv
module thq_ctrl_reg
    import thq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output thq_ctrl_t   ctrl,
    output logic        clr_req
);
    logic wr_hi;
    thq_ctrl_t ctrl_q;

    assign wr_hi   = we & be[1];
    assign clr_req = wr_hi & ~wdata[8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hi) begin
            ctrl_q.rate  <= wdata[15:14];
            ctrl_q.en    <= wdata[13];
            ctrl_q.nsamp <= wdata[12:10];
            ctrl_q.pd    <= wdata[9];
        end
    end

    assign ctrl = ctrl_q;

    // R9: without the upper lane nothing in the word changes
    a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(ctrl_q));
endmodule

// File: rtl/thq_debounce.sv
module thq_debounce
    import thq_pkg::*;
#(
    parameter int MAX_SAMPLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] nsamp,
    input  logic       tick,
    input  logic       samp,
    input  logic       clr_req,
    output logic       hit_o
);
    localparam int RUN_W = $clog2(MAX_SAMPLES + 1);

    thq_state_e state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [3:0]       code_plus;
    logic [RUN_W:0]   need;
    logic [RUN_W:0]   run_inc;

    assign code_plus = {1'b0, nsamp} + 4'd1;
    assign need      = (code_plus > 4'(MAX_SAMPLES)) ? (RUN_W+1)'(MAX_SAMPLES)
                                                     : (RUN_W+1)'(code_plus);
    assign run_inc   = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (!en) begin
            state_d = ST_OFF;
            run_d   = '0;
        end else if (clr_req && state_q != ST_OFF) begin
            state_d = ST_COUNT;
            run_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_COUNT;
                    run_d   = '0;
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (!samp) begin
                            run_d = '0;
                        end else if (run_inc >= need) begin
                            state_d = ST_HIT;
                            run_d   = '0;
                        end else begin
                            run_d = run_inc[RUN_W-1:0];
                        end
                    end
                end
                ST_HIT: begin
                    state_d = ST_HIT;
                end
                default: begin
                    state_d = ST_OFF;
                    run_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        hit_o = (state_q == ST_HIT);
    end

    // R5: a result rises only after a high sample taken on a tick
    a_r5_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> ($past(samp) && $past(tick)));
    // R5: sticky while enabled and not soft-cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && en && !clr_req) |=> hit_o);
    // R7: disabled detector drops the result on the next cycle
    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hit_o);
endmodule

// File: rtl/thresh_qual.sv
module thresh_qual
    import thq_pkg::*;
#(
    parameter int MAX_SAMPLES = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        cmp_in,
    output logic        det_en_o,
    output logic        pwrdn_o,
    output logic        result_o
);
    thq_ctrl_t ctrl;
    logic clr_req;
    logic tick;
    logic samp;
    logic hit;
    logic res_vis;

    thq_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .be      (reg_be),
        .wdata   (reg_wdata),
        .ctrl    (ctrl),
        .clr_req (clr_req)
    );

    thq_prescale #(.PS_W(3)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (ctrl.rate),
        .tick  (tick)
    );

    thq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (samp)
    );

    thq_debounce #(.MAX_SAMPLES(MAX_SAMPLES)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .nsamp   (ctrl.nsamp),
        .tick    (tick),
        .samp    (samp),
        .clr_req (clr_req),
        .hit_o   (hit)
    );

    assign res_vis   = hit & ctrl.en;
    assign reg_rdata = {ctrl.rate, ctrl.en, ctrl.nsamp, ctrl.pd, res_vis, 8'h00};
    assign det_en_o  = ctrl.en;
    assign pwrdn_o   = ctrl.pd;
    assign result_o  = res_vis;

    // R8: power-down output tracks the last upper-lane write of bit 9
    a_r8_pd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_be[1]) |=> (pwrdn_o == $past(reg_wdata[9])));
endmodule

// File: tb/thresh_qual_tb.sv
module thresh_qual_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        cmp_in = 1'b0;
    logic        det_en_o, pwrdn_o, result_o;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit timed_out = 1'b0;
    string tag = "R10";

    always #5 clk = ~clk;

    thresh_qual dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .det_en_o(det_en_o), .pwrdn_o(pwrdn_o), .result_o(result_o)
    );

    // reference state built from the requirements
    logic [2:0] m_pc;
    logic       m_s1, m_s2;
    logic [1:0] m_rate;
    logic       m_en, m_pd;
    logic [2:0] m_code;
    logic       m_on, m_res;
    int         m_run;

    function automatic int req_samples(input logic [2:0] code);
        return (int'(code) + 1 > 5) ? 5 : int'(code) + 1;
    endfunction

    function automatic bit is_tick(input logic [2:0] pc, input logic [1:0] rate);
        int div = 1 << rate;
        return (int'(pc) % div) == 0;
    endfunction

    function automatic logic [15:0] mk(input logic [1:0] rate, input logic en,
                                       input logic [2:0] code, input logic pd,
                                       input logic keep);
        return {rate, en, code, pd, keep, 8'h00};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc <= 3'd0; m_s1 <= 1'b0; m_s2 <= 1'b0;
            m_rate <= 2'd0; m_en <= 1'b0; m_pd <= 1'b0; m_code <= 3'd0;
            m_on <= 1'b0; m_res <= 1'b0; m_run <= 0;
        end else begin
            m_pc <= m_pc + 3'd1;
            m_s1 <= cmp_in;
            m_s2 <= m_s1;
            if (!m_en) begin
                m_on <= 1'b0; m_run <= 0; m_res <= 1'b0;
            end else if (reg_we && reg_be[1] && !reg_wdata[8] && m_on) begin
                m_run <= 0; m_res <= 1'b0;
            end else if (!m_on) begin
                m_on <= 1'b1; m_run <= 0;
            end else if (!m_res && is_tick(m_pc, m_rate)) begin
                if (!m_s2) m_run <= 0;
                else if (m_run + 1 >= req_samples(m_code)) begin
                    m_res <= 1'b1; m_run <= 0;
                end else m_run <= m_run + 1;
            end
            if (reg_we && reg_be[1]) begin
                m_rate <= reg_wdata[15:14]; m_en <= reg_wdata[13];
                m_code <= reg_wdata[12:10]; m_pd <= reg_wdata[9];
            end
        end
    end

    task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            check({tag, " rdata"}, {16'h0, reg_rdata},
                  {16'h0, m_rate, m_en, m_code, m_pd, m_res & m_en, 8'h00});
            check({tag, " result_o"}, {31'h0, result_o}, {31'h0, m_res & m_en});
            check({tag, " pins"}, {30'h0, det_en_o, pwrdn_o}, {30'h0, m_en, m_pd});
        end
    end

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_main;
        // R10: reset state
        idle(2);
        check("R10 reset rdata", {16'h0, reg_rdata}, 32'h0);
        check("R10 reset outputs", {29'h0, det_en_o, pwrdn_o, result_o}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        check("R10 after reset", {16'h0, reg_rdata}, 32'h0);
        chk_on = 1'b1;

        // R2: exact synchronizer latency
        tag = "R2";
        wr(2'b10, mk(2'd0, 1'b1, 3'd0, 1'b0, 1'b1));
        idle(4);
        cmp_in = 1'b1;
        idle(2);
        check("R2 two edges", {31'h0, result_o}, 32'h0);
        idle(1);
        check("R2 third edge", {31'h0, result_o}, 32'h1);

        // R5: sticky against a low input
        tag = "R5";
        cmp_in = 1'b0;
        idle(12);
        check("R5 sticky", {31'h0, result_o}, 32'h1);

        // R6: write bit8=0 clears, write 1 does not set
        tag = "R6";
        wr(2'b10, mk(2'd0, 1'b1, 3'd2, 1'b0, 1'b0));
        idle(3);
        check("R6 cleared", {31'h0, result_o}, 32'h0);
        wr(2'b10, mk(2'd0, 1'b1, 3'd2, 1'b0, 1'b1));
        idle(3);
        check("R6 no set", {31'h0, result_o}, 32'h0);

        // R1: each rate with a steady high input after a clear
        for (int r = 0; r < 4; r++) begin
            tag = "R1";
            cmp_in = 1'b0;
            wr(2'b10, mk(2'(r), 1'b1, 3'd3, 1'b0, 1'b0));
            idle(5);
            cmp_in = 1'b1;
            idle(45);
        end

        // R3: saturation codes and a run one short
        for (int c = 3; c < 8; c++) begin
            tag = "R3";
            cmp_in = 1'b0;
            wr(2'b10, mk(2'd1, 1'b1, 3'(c), 1'b0, 1'b0));
            idle(4);
            cmp_in = 1'b1;
            idle(2 * req_samples(3'(c)) - 1);
            cmp_in = 1'b0;
            idle(6);
            cmp_in = 1'b1;
            idle(20);
        end

        // R4: runs broken by a low sample
        tag = "R4";
        cmp_in = 1'b0;
        wr(2'b10, mk(2'd0, 1'b1, 3'd4, 1'b0, 1'b0));
        for (int k = 0; k < 6; k++) begin
            cmp_in = 1'b1; idle(4);
            cmp_in = 1'b0; idle(1);
        end
        check("R4 no qualify", {31'h0, result_o}, 32'h0);

        // R7: disable mid-run and re-enable
        tag = "R7";
        cmp_in = 1'b1;
        idle(3);
        wr(2'b10, mk(2'd0, 1'b0, 3'd4, 1'b0, 1'b1));
        idle(6);
        check("R7 disabled", {31'h0, result_o}, 32'h0);
        wr(2'b10, mk(2'd0, 1'b1, 3'd4, 1'b0, 1'b1));
        idle(15);

        // R8: power-down pin
        tag = "R8";
        wr(2'b10, mk(2'd2, 1'b0, 3'd1, 1'b1, 1'b0));
        idle(2);
        check("R8 pd high", {31'h0, pwrdn_o}, 32'h1);
        wr(2'b10, mk(2'd2, 1'b1, 3'd1, 1'b0, 1'b0));
        idle(2);
        check("R8 pd low", {31'h0, pwrdn_o}, 32'h0);

        // R9: lower lane writes are ignored
        tag = "R9";
        wr(2'b01, 16'hFFFF);
        idle(2);
        check("R9 lane ignore", {16'h0, reg_rdata[15:9], 9'h0},
              {16'h0, 2'd2, 1'b1, 3'd1, 1'b0, 9'h0});
        check("R9 low byte", {24'h0, reg_rdata[7:0]}, 32'h0);

        // random mix
        tag = "R5 random";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cmp_in = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 39) == 0) begin
                reg_we = 1'b1;
                reg_be = 2'($urandom_range(0, 3));
                reg_wdata = 16'($urandom) | 16'h2000;
                if ($urandom_range(0, 7) == 0) reg_wdata[13] = 1'b0;
            end else begin
                reg_we = 1'b0; reg_be = 2'b00;
            end
        end
        reg_we = 1'b0;
        idle(3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule